// File: doc/BRIEF.md
# Configuration Request PIO Engine

This block lets software issue one outbound configuration transaction at a time through a small 32-bit register window. Software writes the transaction type, a 64-bit target address, write data and a byte-lane strobe. It then sets bit 0 of the start register. The engine presents the request to a link-layer stub on a valid/ready handshake and waits for a single completion beat. It records the completion outcome in a status register and raises an interrupt flag.

While a request is in flight, the start register reads back as 1. The request-side registers are frozen during this time, so the outbound fields cannot change under the link layer. If no completion arrives within `TIMEOUT_CYC` cycles of launch, the engine closes the request itself with an abort outcome. Read data is kept only from a read that completes cleanly.

Top module: `cfg_pio_engine`

## Requirements
- R1: After reset every register reads 0 at every offset, `req_valid` is 0 and `irq` is 0.
- R2: The register offsets are fixed as follows, and each readable register returns what was written. Unimplemented bits read 0.
  - 0x00 control: type in bits 3:0, window-bypass flag in bit 24.
  - 0x08 address low.
  - 0x0C address high.
  - 0x10 write data.
  - 0x14 strobe: bits 3:0.
  - The request outputs follow these registers.
- R3: Writing a value with bit 0 set to the start register (0x1C) while idle launches a request. From the next cycle `req_valid` is 1 and the start register reads 1 until the request finishes.
- R4: `req_valid` stays high until `req_ready` is sampled high, then drops on that same edge.
- R5: A `cpl_valid` beat sampled after acceptance ends the request on that edge. Busy clears, and bit 0 of the interrupt status register (0x20) and `irq` both go to 1. The status register (0x04) captures the following:
  - bits 9:7: the completion code;
  - bit 10: type bit 3, which marks a non-posted request;
  - bit 11: the error flag.
- R6: The read data register (0x18) is loaded from `cpl_data` only when the type is a read (type bit 1 = 0), the completion code is 0 and the error flag is 0. Otherwise it keeps its value.
- R7: Writing 1 to bit 0 of the interrupt status register clears it. Writing 0 leaves it set.
- R8: While busy, these writes are ignored:
  - writes to start, control, address, write data and strobe are ignored;
  - the request outputs and those registers' readback stay unchanged.
- R9: With no completion, the request ends on the `TIMEOUT_CYC`-th clock edge after launch. The status shows code 4 with the error flag set, and `irq` is set.
- R10: A `cpl_valid` beat while idle, or before the request is accepted, is ignored. Status, read data, busy and `irq` are unchanged.
- R11: Completion codes are stored unmodified, including values outside {0,1,2,4}, such as 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | REG_AW | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| req_valid | output | 1 | Outbound request valid |
| req_ready | input | 1 | Link layer accepts the request |
| req_type | output | 4 | Transaction type |
| req_win_bypass | output | 1 | Skip address-window translation |
| req_addr | output | 64 | Target address |
| req_wdata | output | 32 | Write payload |
| req_strobe | output | 4 | Byte-lane enables |
| cpl_valid | input | 1 | Completion beat |
| cpl_code | input | 3 | Completion code |
| cpl_err | input | 1 | Completion error flag |
| cpl_data | input | 32 | Completion read data |
| irq | output | 1 | Interrupt status bit 0 |

## Verification
The bench walks a table of reads, writes, posted and non-posted types through every completion code, including the unknown code 3 and a clean code with the error flag. A design that loaded read data on a write, on an error or on a non-zero code would show a changed 0x18 value.

Directed cases cover the following:
- A second start and register writes during a transfer: a design that relaunched or let the fields move would show a changed `req_addr` or readback.
- A completion beat before acceptance or while idle: a design that took it would drop busy or set `irq` early.
- The timeout window is counted edge by edge. An off-by-one counter shows busy one cycle early or late.

// File: rtl/cfg_pio_pkg.sv
package cfg_pio_pkg;
   localparam int DW = 32;

   localparam logic [7:0] OFF_CTRL  = 8'h00;
   localparam logic [7:0] OFF_STAT  = 8'h04;
   localparam logic [7:0] OFF_ADRL  = 8'h08;
   localparam logic [7:0] OFF_ADRH  = 8'h0C;
   localparam logic [7:0] OFF_WDAT  = 8'h10;
   localparam logic [7:0] OFF_STRB  = 8'h14;
   localparam logic [7:0] OFF_RDAT  = 8'h18;
   localparam logic [7:0] OFF_START = 8'h1C;
   localparam logic [7:0] OFF_ISR   = 8'h20;

   localparam int BYP_BIT = 24;

   localparam logic [2:0] CODE_ABORT = 3'd4;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_REQ  = 2'd1,
      SQ_WAIT = 2'd2
   } seq_state_e;
endpackage

// File: rtl/cfg_pio_timer.sv
module cfg_pio_timer #(
   parameter int TIMEOUT_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   output logic expired
);
   localparam int CW = (TIMEOUT_CYC < 2) ? 1 : $clog2(TIMEOUT_CYC + 1);

   generate
      if (TIMEOUT_CYC == 0) begin : g_off
         assign expired = 1'b0;
      end else begin : g_on
         localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !busy) cnt <= '0;
            else if (cnt != LAST) cnt <= cnt + 1'b1;
         end
         assign expired = busy && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/cfg_pio_seq.sv
module cfg_pio_seq
   import cfg_pio_pkg::*;
#(
   parameter int TIMEOUT_CYC = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       launch,
   input  logic       req_ready,
   input  logic       cpl_valid,
   input  logic [2:0] cpl_code,
   input  logic       cpl_err,
   output logic       busy,
   output logic       req_valid,
   output logic       done,
   output logic [2:0] done_code,
   output logic       done_err
);
   seq_state_e st;
   logic       expired;
   logic       cpl_take;

   cfg_pio_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (busy),
      .expired (expired)
   );

   assign busy      = (st != SQ_IDLE);
   assign req_valid = (st == SQ_REQ);
   assign cpl_take  = (st == SQ_WAIT) && cpl_valid;
   assign done      = cpl_take || expired;
   assign done_code = cpl_take ? cpl_code : CODE_ABORT;
   assign done_err  = cpl_take ? cpl_err  : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= SQ_IDLE;
      end else begin
         unique case (st)
            SQ_IDLE: if (launch) st <= SQ_REQ;
            SQ_REQ:  if (expired) st <= SQ_IDLE;
                     else if (req_ready) st <= SQ_WAIT;
            SQ_WAIT: if (done) st <= SQ_IDLE;
            default: st <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine
   import cfg_pio_pkg::*;
#(
   parameter int REG_AW      = 8,
   parameter int TIMEOUT_CYC = 16,
   parameter bit HAS_HI_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [3:0]        req_type,
   output logic              req_win_bypass,
   output logic [63:0]       req_addr,
   output logic [31:0]       req_wdata,
   output logic [3:0]        req_strobe,
   input  logic              cpl_valid,
   input  logic [2:0]        cpl_code,
   input  logic              cpl_err,
   input  logic [31:0]       cpl_data,
   output logic              irq
);
   initial begin
      if (REG_AW < 6) $error("REG_AW too small for register map");
      if (TIMEOUT_CYC == 1) $error("TIMEOUT_CYC must be 0 or at least 2");
   end

   logic        busy, done, done_err;
   logic [2:0]  done_code;
   logic [3:0]  ctrl_type;
   logic        ctrl_byp;
   logic [31:0] addr_lo, addr_hi, wdat_q, rd_data_q;
   logic [3:0]  strb_q;
   logic [2:0]  stat_code;
   logic        stat_np, stat_err, isr_q;
   logic        wr_ok, launch, rd_load;

   function automatic logic hit(input logic [REG_AW-1:0] a, input logic [7:0] off);
      return a == REG_AW'(off);
   endfunction

   assign wr_ok   = bus_wr && !busy;
   assign launch  = wr_ok && hit(bus_addr, OFF_START) && bus_wdata[0];
   assign rd_load = done && !ctrl_type[1] && (done_code == 3'd0) && !done_err;

   cfg_pio_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .req_ready (req_ready),
      .cpl_valid (cpl_valid),
      .cpl_code  (cpl_code),
      .cpl_err   (cpl_err),
      .busy      (busy),
      .req_valid (req_valid),
      .done      (done),
      .done_code (done_code),
      .done_err  (done_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_type <= '0;
         ctrl_byp  <= 1'b0;
         addr_lo   <= '0;
         wdat_q    <= '0;
         strb_q    <= '0;
      end else if (wr_ok) begin
         if (hit(bus_addr, OFF_CTRL)) begin
            ctrl_type <= bus_wdata[3:0];
            ctrl_byp  <= bus_wdata[BYP_BIT];
         end
         if (hit(bus_addr, OFF_ADRL)) addr_lo <= bus_wdata;
         if (hit(bus_addr, OFF_WDAT)) wdat_q  <= bus_wdata;
         if (hit(bus_addr, OFF_STRB)) strb_q  <= bus_wdata[3:0];
      end
   end

   generate
      if (HAS_HI_ADDR) begin : g_hi
         always_ff @(posedge clk) begin
            if (!rst_n) addr_hi <= '0;
            else if (wr_ok && hit(bus_addr, OFF_ADRH)) addr_hi <= bus_wdata;
         end
      end else begin : g_nohi
         assign addr_hi = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_code <= '0;
         stat_np   <= 1'b0;
         stat_err  <= 1'b0;
         rd_data_q <= '0;
         isr_q     <= 1'b0;
      end else begin
         if (done) begin
            stat_code <= done_code;
            stat_np   <= ctrl_type[3];
            stat_err  <= done_err;
         end
         if (rd_load) rd_data_q <= cpl_data;
         if (done) isr_q <= 1'b1;
         else if (bus_wr && hit(bus_addr, OFF_ISR) && bus_wdata[0]) isr_q <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit(bus_addr, OFF_CTRL)) begin
         bus_rdata[3:0]     = ctrl_type;
         bus_rdata[BYP_BIT] = ctrl_byp;
      end
      if (hit(bus_addr, OFF_STAT)) bus_rdata[11:7] = {stat_err, stat_np, stat_code};
      if (hit(bus_addr, OFF_ADRL)) bus_rdata = addr_lo;
      if (hit(bus_addr, OFF_ADRH)) bus_rdata = addr_hi;
      if (hit(bus_addr, OFF_WDAT)) bus_rdata = wdat_q;
      if (hit(bus_addr, OFF_STRB)) bus_rdata[3:0] = strb_q;
      if (hit(bus_addr, OFF_RDAT)) bus_rdata = rd_data_q;
      if (hit(bus_addr, OFF_START)) bus_rdata[0] = busy;
      if (hit(bus_addr, OFF_ISR)) bus_rdata[0] = isr_q;
   end

   assign req_type       = ctrl_type;
   assign req_win_bypass = ctrl_byp;
   assign req_addr       = {addr_hi, addr_lo};
   assign req_wdata      = wdat_q;
   assign req_strobe     = strb_q;
   assign irq            = isr_q;
endmodule

// File: rtl/cfg_pio_engine_chk.sv
module cfg_pio_engine_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        req_valid,
   input logic        req_ready,
   input logic [3:0]  req_type,
   input logic [63:0] req_addr,
   input logic        cpl_valid,
   input logic [2:0]  cpl_code,
   input logic        cpl_err,
   input logic        irq,
   input logic [31:0] rd_data
);
   // R3
   launch_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> req_valid);

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid || !busy);

   // R5
   cpl_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !req_valid && cpl_valid |=> !busy && irq);

   // R6
   rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_data) |-> $past(cpl_valid) && ($past(cpl_code) == 3'd0) && !$past(cpl_err));

   // R8
   req_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(req_addr) && $stable(req_type));
endmodule

bind cfg_pio_engine cfg_pio_engine_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_type  (req_type),
   .req_addr  (req_addr),
   .cpl_valid (cpl_valid),
   .cpl_code  (cpl_code),
   .cpl_err   (cpl_err),
   .irq       (irq),
   .rd_data   (rd_data_q)
);

// File: tb/test_cfg_pio_engine.sv
module test_cfg_pio_engine;
   localparam int AW = 8;
   localparam int TMO = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        req_valid, req_win_bypass;
   logic        req_ready = 1'b0;
   logic [3:0]  req_type, req_strobe;
   logic [63:0] req_addr;
   logic [31:0] req_wdata;
   logic        cpl_valid = 1'b0;
   logic [2:0]  cpl_code = '0;
   logic        cpl_err = 1'b0;
   logic [31:0] cpl_data = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_rd = '0;

   always #10 clk = ~clk;

   cfg_pio_engine #(.REG_AW(AW), .TIMEOUT_CYC(TMO)) i_cfg_pio_engine (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
      .req_ready(req_ready), .req_type(req_type), .req_win_bypass(req_win_bypass),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_strobe(req_strobe),
      .cpl_valid(cpl_valid), .cpl_code(cpl_code), .cpl_err(cpl_err),
      .cpl_data(cpl_data), .irq(irq)
   );

   // {type, code, err, cpl data, expected status, expected load}
   localparam logic [52:0] VEC [9] = '{
      {4'h8, 3'd0, 1'b0, 32'hA5A5_0001, 12'h400, 1'b1},
      {4'hA, 3'd0, 1'b0, 32'h1111_2222, 12'h400, 1'b0},
      {4'h9, 3'd1, 1'b0, 32'h3333_4444, 12'h480, 1'b0},
      {4'h8, 3'd0, 1'b1, 32'h5555_6666, 12'hC00, 1'b0},
      {4'h9, 3'd2, 1'b0, 32'h7777_8888, 12'h500, 1'b0},
      {4'hB, 3'd4, 1'b0, 32'h9999_AAAA, 12'h600, 1'b0},
      {4'h8, 3'd3, 1'b0, 32'hBBBB_CCCC, 12'h580, 1'b0},
      {4'h1, 3'd0, 1'b0, 32'hDDDD_EEEE, 12'h000, 1'b1},
      {4'h9, 3'd0, 1'b0, 32'h1234_5678, 12'h400, 1'b1}
   };

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic accept();
      @(negedge clk);
      req_ready = 1'b1;
      @(posedge clk);
      #1 req_ready = 1'b0;
   endtask

   task automatic complete(input logic [2:0] c, input logic e, input logic [31:0] d);
      @(negedge clk);
      cpl_valid = 1'b1; cpl_code = c; cpl_err = e; cpl_data = d;
      @(posedge clk);
      #1 cpl_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      // R1 reset state
      repeat (3) @(posedge clk);
      for (int a = 0; a <= 8'h20; a += 4) begin
         rd(8'(a), v);
         check($sformatf("R1 reg %0h", a), v, 0);
      end
      check("R1 req_valid", req_valid, 0);
      check("R1 irq", irq, 0);
      @(negedge clk) rst_n = 1'b1;

      // R2 register readback and request outputs
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, v); check("R2 ctrl", v, 32'h0100_000F);
      check("R2 bypass out", req_win_bypass, 1);
      wr(8'h14, 32'hFFFF_FFF5);
      rd(8'h14, v); check("R2 strobe", v, 32'h5);
      wr(8'h0C, 32'hDEAD_BEEF);
      wr(8'h08, 32'h0010_0000);
      rd(8'h0C, v); check("R2 addr hi", v, 32'hDEAD_BEEF);
      check("R2 req_addr", req_addr, 64'hDEAD_BEEF_0010_0000);
      wr(8'h10, 32'hCAFE_F00D);
      rd(8'h10, v); check("R2 wdata", v, 32'hCAFE_F00D);
      check("R2 req_wdata", req_wdata, 32'hCAFE_F00D);

      // table walk: R3 R4 R5 R6 R11
      foreach (VEC[i]) begin
         logic [3:0]  t;
         logic [2:0]  c;
         logic        e, ld;
         logic [31:0] d;
         logic [11:0] es;
         {t, c, e, d, es, ld} = VEC[i];
         wr(8'h00, {28'h0, t});
         wr(8'h20, 32'h1);
         wr(8'h1C, 32'h1);
         @(negedge clk);
         check($sformatf("R3 req_valid v%0d", i), req_valid, 1);
         check($sformatf("R3 req_type v%0d", i), req_type, t);
         rd(8'h1C, v); check($sformatf("R3 busy v%0d", i), v, 1);
         accept();
         @(negedge clk);
         check($sformatf("R4 drop v%0d", i), req_valid, 0);
         complete(c, e, d);
         if (ld) exp_rd = d;
         rd(8'h1C, v); check($sformatf("R5 idle v%0d", i), v, 0);
         check($sformatf("R5 irq v%0d", i), irq, 1);
         rd(8'h20, v); check($sformatf("R5 isr v%0d", i), v, 1);
         rd(8'h04, v); check($sformatf("R5 R11 status v%0d", i), v, {20'h0, es});
         rd(8'h18, v); check($sformatf("R6 rdata v%0d", i), v, exp_rd);
      end

      // R7 write 0 keeps isr, write 1 clears
      wr(8'h20, 32'h0);
      check("R7 isr kept", irq, 1);
      wr(8'h20, 32'h1);
      check("R7 isr cleared", irq, 0);

      // R8 writes during busy are ignored
      wr(8'h00, 32'h8);
      wr(8'h08, 32'h0000_0100);
      wr(8'h1C, 32'h1);
      wr(8'h08, 32'h0000_0200);
      wr(8'h00, 32'hA);
      wr(8'h1C, 32'h1);
      check("R8 req_addr", req_addr[31:0], 32'h100);
      check("R8 req_type", req_type, 4'h8);
      // R10 completion before acceptance ignored
      complete(3'd2, 1'b0, 32'h0BAD_0BAD);
      rd(8'h1C, v); check("R10 busy before accept", v, 1);
      check("R10 irq before accept", irq, 0);
      accept();
      complete(3'd0, 1'b0, 32'h600D_600D);
      exp_rd = 32'h600D_600D;
      rd(8'h08, v); check("R8 addr lo kept", v, 32'h100);
      rd(8'h00, v); check("R8 ctrl kept", v, 32'h8);
      rd(8'h18, v); check("R6 rdata after R8", v, exp_rd);

      // R10 completion while idle ignored
      wr(8'h20, 32'h1);
      complete(3'd1, 1'b1, 32'hFFFF_0000);
      check("R10 idle irq", irq, 0);
      rd(8'h04, v); check("R10 idle status", v, 32'h400);
      rd(8'h18, v); check("R10 idle rdata", v, exp_rd);

      // R9 timeout
      wr(8'h1C, 32'h1);
      repeat (TMO - 1) @(posedge clk);
      rd(8'h1C, v); check("R9 busy before window", v, 1);
      @(posedge clk);
      rd(8'h1C, v); check("R9 done at window", v, 0);
      check("R9 irq", irq, 1);
      rd(8'h04, v); check("R9 status", v, 32'hE00);
      rd(8'h18, v); check("R9 rdata kept", v, exp_rd);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule